// File: doc/BRIEF.md
# Two-Digit BCD Rate Multiplier

This block thins a stream of reference pulses so that, on average, N of every 100 pass through, where N is a two-digit BCD word from 00 to 99. The reference pulses arrive as a one-cycle clock enable. A chain of decade stages does the counting, one stage per BCD digit. The stage for the tens digit counts every reference pulse and passes its share of them directly. Once per ten reference pulses it hands a carry to the units stage, which passes its share of those carries. Each stage picks its pulses from bit-weighted phases of its own decade count. Weight 1 owns one count position, weight 2 owns two, weight 4 owns four and weight 8 owns eight. A digit therefore selects exactly that many of its ten positions, spread across the count. No stage ever selects position 9. That is the position on which it carries, so two stages can never fire on the same reference pulse.

Every selected pulse becomes an event. The event is stretched into a fixed-width output pulse that lasts a parameterised number of clocks. The block can then drive the fractional request input of a pulse-swallowing divider sequencer. With a 500 kHz reference the output averages N × 5 kHz.

Top module: `bcd_rate_mult`

## Requirements
- R1: Over any 100 consecutive reference enables, exactly 10·T + U output pulses are produced. T is the tens digit and U is the units digit, each after the limit of R3. Two stage selections never coincide.
- R2: The word `bcd_n` carries the tens digit in bits [7:4] and the units digit in bits [3:0].
- R3: A digit value from 10 to 15 behaves exactly as the value 9.
- R4: With `bcd_n` = 8'h00 the output never goes high.
- R5: With the units digit at 0, every run of 10 consecutive reference enables that starts at a decade boundary after reset yields exactly T output pulses.
- R6: While `ref_en` is low no event occurs, and the stage counts do not change.
- R7: An event sampled at a clock edge sets `pulse_o` high from that edge on, for exactly PULSE_CYCLES clocks.
- R8: An event that arrives while the output pulse is still high is ignored. The pulse is neither extended nor restarted.
- R9: Synchronous active-low reset sets `pulse_o` low and returns every stage count to position 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_en | input | 1 | One-cycle enable at the reference pulse rate |
| bcd_n | input | 8 | Rate word: tens digit in [7:4], units digit in [3:0] |
| pulse_o | output | 1 | Stretched output pulse, PULSE_CYCLES clocks wide |

## Verification
An event is formed in the same cycle as the reference enable. It is registered by the stretcher at that clock edge, so `pulse_o` rises one edge after the enable is sampled and stays high for PULSE_CYCLES clocks. The bench drives the enable and samples `pulse_o` on falling edges. It counts rising edges of `pulse_o` across each 100-enable or 10-enable window. It spaces enables ten clocks apart, which is wider than the pulse. After the last enable of a window it waits out a full pulse width before it compares the count. The width and retrigger checks measure the length of each high run clock by clock.

// File: rtl/bcd_rm_pkg.sv
// Package: shared constants and helper functions for the BCD rate multiplier.
// Assumes digits are 4-bit BCD. Values above 9 are limited to 9.
package bcd_rm_pkg;

    localparam int DIGIT_W = 4;
    localparam int POS_LAST = 9;

    // Limit a raw 4-bit digit to the decimal range 0..9.
    function automatic logic [DIGIT_W-1:0] clamp_digit(input logic [DIGIT_W-1:0] d);
        return (d > 4'd9) ? 4'd9 : d;
    endfunction

    // Decide whether count position 'pos' is selected for digit 'd' (already limited).
    // Weight 1 owns {4}. Weight 2 owns {2,7}. Weight 4 owns {0,3,5,8}.
    // Weight 8 owns every position except 4 and 9.
    // Position 9 is never selected, so a stage never fires on its carry cycle.
    function automatic logic phase_hit(input logic [DIGIT_W-1:0] pos,
                                       input logic [DIGIT_W-1:0] d);
        logic hit;
        hit = 1'b0;
        if (d[0] && pos == 4'd4)
            hit = 1'b1;
        if (d[1] && (pos == 4'd2 || pos == 4'd7))
            hit = 1'b1;
        if (d[2] && (pos == 4'd0 || pos == 4'd3 || pos == 4'd5 || pos == 4'd8))
            hit = 1'b1;
        if (d[3] && pos != 4'd4 && pos != 4'd9)
            hit = 1'b1;
        return hit;
    endfunction

endpackage

// File: rtl/bcd_rm_decade.sv
// Module: one decade rate-multiplier stage.
// Counts 'step' pulses through positions 0..9. It asserts 'pass' on the steps whose
// position is selected by the digit, and 'wrap' on the step taken at position 9.
// Assumes 'step' is a single-cycle strobe. Reset is synchronous and active low.
module bcd_rm_decade
    import bcd_rm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step,
    input  logic [DIGIT_W-1:0] digit,
    output logic [DIGIT_W-1:0] pos,
    output logic               pass,
    output logic               wrap
);

    logic [DIGIT_W-1:0] digit_lim;

    // Limit the incoming digit to 0..9.
    always_comb digit_lim = clamp_digit(digit);

    // Advance the decade position on each step, returning to 0 after 9.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos <= '0;
        else if (step)
            pos <= (pos == DIGIT_W'(POS_LAST)) ? '0 : pos + 1'b1;
    end

    // Select this step if its position belongs to the digit's weighted phases.
    always_comb pass = step && phase_hit(pos, digit_lim);

    // Carry out on the step that leaves position 9.
    always_comb wrap = step && (pos == DIGIT_W'(POS_LAST));

    // R5: the position stays within the decade.
    a_r5_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= DIGIT_W'(POS_LAST));

    // R6: without a step the position holds.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(pos));

    // R1: a stage never selects its own carry step.
    a_r1_no_pass_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> !pass);

endmodule

// File: rtl/bcd_rm_stretch.sv
// Module: fixed-width pulse stretcher that stands in for a one-shot.
// On an event while idle it drives 'pulse_o' high for PULSE_CYCLES clocks.
// Events that arrive while busy are dropped. Reset is synchronous and active low.
module bcd_rm_stretch #(
    parameter int PULSE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic event_i,
    output logic pulse_o
);

    localparam int CNT_W = $clog2(PULSE_CYCLES + 1);

    logic [CNT_W-1:0] remain;

    // Load the width on an idle event, otherwise count the active pulse down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (remain != '0)
            remain <= remain - 1'b1;
        else if (event_i)
            remain <= CNT_W'(PULSE_CYCLES);
    end

    // The output is high while clocks remain in the stretch.
    always_comb pulse_o = (remain != '0);

    // R7: an idle event raises the output at the next edge.
    a_r7_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
        (event_i && !pulse_o) |=> pulse_o);

    // R8: while busy, every edge shortens the stretch by one, whatever the event input does.
    a_r8_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        (remain != '0) |=> (remain == $past(remain) - 1'b1));

endmodule

// File: rtl/bcd_rate_mult.sv
// Module: BCD rate multiplier top. It passes N of every 100 reference enables,
// where N is a DIGITS-digit BCD word, and stretches each event into a fixed pulse.
// The most significant stage counts 'ref_en'. Each lower stage counts carries
// from the stage above it. Stage selections are ORed into one event.
// Assumes 'ref_en' is a one-cycle strobe. Reset is synchronous and active low.
module bcd_rate_mult
    import bcd_rm_pkg::*;
#(
    parameter int DIGITS       = 2,
    parameter int PULSE_CYCLES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ref_en,
    input  logic [DIGITS*DIGIT_W-1:0] bcd_n,
    output logic                      pulse_o
);

    localparam int N_W = DIGITS * DIGIT_W;

    logic [DIGITS:0]        step;
    logic [DIGITS-1:0]      pass;
    logic [DIGIT_W-1:0]     pos [DIGITS];
    logic                   event_w;

    // Feed the reference enable into the most significant stage.
    always_comb step[DIGITS] = ref_en;

    // One decade stage per digit. Stage k steps on the carry of stage k+1.
    for (genvar k = 0; k < DIGITS; k++) begin : g_stage
        bcd_rm_decade u_dec (
            .clk   (clk),
            .rst_n (rst_n),
            .step  (step[k+1]),
            .digit (bcd_n[k*DIGIT_W +: DIGIT_W]),
            .pos   (pos[k]),
            .pass  (pass[k]),
            .wrap  (step[k])
        );
    end

    // Combine the selections of all stages into a single event.
    always_comb event_w = |pass;

    bcd_rm_stretch #(
        .PULSE_CYCLES (PULSE_CYCLES)
    ) u_stretch (
        .clk     (clk),
        .rst_n   (rst_n),
        .event_i (event_w),
        .pulse_o (pulse_o)
    );

    // R1: at most one stage selects on any reference enable.
    a_r1_no_collide: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pass));

    // R4: a zero rate word never produces an event.
    a_r4_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bcd_n == N_W'(0)) |-> !event_w);

    // R6: no event without a reference enable.
    a_r6_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_en |-> !event_w);

    // R9: after a full-chain carry the least significant stage is back at position 0.
    a_r9_full_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        step[0] |=> (pos[0] == '0));

endmodule

// File: tb/sim_bcd_rate_mult.sv
module sim_bcd_rate_mult;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_en = 1'b0;
    logic [7:0] bcd_n = 8'h00;
    logic       pulse_o;

    localparam int PW = 4;

    int checks = 0;
    int fails  = 0;
    int rises  = 0;
    int run    = 0;
    int max_run = 0;
    logic prev = 1'b0;

    always #4 clk = ~clk;

    bcd_rate_mult #(.DIGITS(2), .PULSE_CYCLES(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .bcd_n(bcd_n), .pulse_o(pulse_o)
    );

    // Rising edge and high-run monitor, sampled on falling edges.
    always @(negedge clk) begin
        if (pulse_o && !prev) rises++;
        if (pulse_o) begin
            run++;
            if (run > max_run) max_run = run;
        end else begin
            run = 0;
        end
        prev = pulse_o;
    end

    // Vectors: {bcd word, expected pulses per 100 enables}.
    localparam int NV = 11;
    localparam logic [15:0] VEC [NV] = '{
        {8'h00, 8'd0},  {8'h01, 8'd1},  {8'h10, 8'd10}, {8'h37, 8'd37},
        {8'h50, 8'd50}, {8'h99, 8'd99}, {8'h09, 8'd9},  {8'h90, 8'd90},
        {8'hA5, 8'd95}, {8'h3F, 8'd39}, {8'hFF, 8'd99}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ref_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rises = 0;
        max_run = 0;
    endtask

    // One reference enable followed by nine idle clocks.
    task automatic tick();
        ref_en = 1'b1;
        @(negedge clk);
        ref_en = 1'b0;
        repeat (9) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        // R9: reset state, with ref_en held high during reset.
        bcd_n = 8'h99;
        ref_en = 1'b1;
        repeat (4) @(negedge clk);
        check("R9 reset output low", int'(pulse_o), 0);
        ref_en = 1'b0;
        do_reset();
        check("R9 no pulse after reset", rises, 0);

        // R1 R2 R3 R4: rate over 100 enables for every vector.
        for (int v = 0; v < NV; v++) begin
            bcd_n = VEC[v][15:8];
            do_reset();
            for (int i = 0; i < 100; i++) tick();
            repeat (PW + 2) @(negedge clk);
            check($sformatf("R1 R2 R3 R4 rate for word %02h", VEC[v][15:8]),
                  rises, int'(VEC[v][7:0]));
        end

        // R5: tens-only words give T pulses in every aligned decade.
        for (int t = 1; t <= 9; t += 4) begin
            bcd_n = {4'(t), 4'h0};
            do_reset();
            for (int w = 0; w < 10; w++) begin
                rises = 0;
                for (int i = 0; i < 10; i++) tick();
                check($sformatf("R5 decade %0d tens %0d", w, t), rises, t);
            end
        end

        // R7: timing and width of one pulse (position 0 is selected by weight 8).
        bcd_n = 8'h90;
        do_reset();
        check("R7 low before enable", int'(pulse_o), 0);
        ref_en = 1'b1;
        @(negedge clk);
        ref_en = 1'b0;
        check("R7 high one edge after enable", int'(pulse_o), 1);
        repeat (PW + 3) @(negedge clk);
        check("R7 width", max_run, PW);

        // R6: no enable, no pulse, and the count does not advance.
        bcd_n = 8'h01;
        do_reset();
        repeat (200) @(negedge clk);
        check("R6 idle no pulse", rises, 0);
        // Units weight 1 fires at units position 4, i.e. the 50th enable from reset.
        for (int i = 0; i < 49; i++) tick();
        check("R6 no pulse before 50th enable", rises, 0);
        tick();
        check("R6 pulse on 50th enable", rises, 1);

        // R8: back-to-back events while busy do not stretch the pulse.
        bcd_n = 8'h90;
        do_reset();
        ref_en = 1'b1;
        repeat (9) @(negedge clk);
        ref_en = 1'b0;
        repeat (PW + 2) @(negedge clk);
        check("R8 run never exceeds width", max_run, PW);
        check("R8 ignored events", rises, 2);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule